// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control state of a 64-bit RISC core: thirty-two registers selected by a five-bit index, read through a combinational port and written on a clock edge. Each access is either a 64-bit move or a 32-bit move. A 32-bit write stores the low word with a zero upper half. A 32-bit read returns the low word sign-extended from bit 31.

Several slots behave differently from plain storage. A cycle counter advances once every `CLK_DIV` core cycles and is compared with a compare register to raise a sticky timer interrupt. A replacement-index generator yields a value that never drops below the wired count. Some slots are read-only constants. The page-mask and wired registers keep only their legal bits. Writes to status, cause or compare emit a one-cycle pulse that tells the interrupt logic to recompute its pending flag. The current privilege mode is taken from a two-bit field of status. Any access made outside kernel mode is refused and raises a trap request.

Top module: `scr_file`

## Requirements
- R1: Synchronous reset clears every stored register, so status reads 0 and the privilege mode is kernel. Reset sets count to 0, compare to 0xFFFFFFFF and the timer interrupt low.
- R2: A read of index 1 (random) and the `rnd_idx` output give wired + (a free-running offset modulo (TLB_ENTRIES − wired)). The value always lies in [wired, TLB_ENTRIES−1]. When wired is TLB_ENTRIES−1 or more, the value is TLB_ENTRIES−1.
- R3: Writes to index 1 (random), 15 (processor ID) and 16 (configuration) have no effect. Index 15 always reads PRID_VAL and index 16 always reads CFG_VAL.
- R4: An accepted write to index 11 (compare) clears the timer interrupt at that edge. An accepted write to index 11, 12 (status) or 13 (cause) makes `irq_recalc` high for exactly the following cycle. Other writes leave it low.
- R5: Index 9 (count) advances by one every CLK_DIV cycles. Writing count loads the low 32 bits and restarts the divider, so the first increment comes CLK_DIV edges after the load.
- R6: The timer interrupt rises on the edge after count equals compare. It stays high until compare is written or reset.
- R7: With `wide`=0, a write stores {32'b0, wr_data[31:0]} and a read returns the low 32 bits sign-extended from bit 31. With `wide`=1, both directions use all 64 bits. Count and compare always read sign-extended from their 32 bits.
- R8: A write to index 5 (page mask) keeps only bits 24..13. A write to index 6 (wired) keeps only the low clog2(TLB_ENTRIES) bits.
- R9: `priv_mode` is status bits 4..3, where 00 means kernel. A read or write while that field is not 00 asserts `trap` in the same cycle. Such a write changes nothing, and such a read returns 0.
- R10: Every other index stores the full written value and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_idx | input | 5 | Register index for the read or write |
| rd_en | input | 1 | Read strobe; `rd_data` is valid in the same cycle |
| wr_en | input | 1 | Write strobe; takes effect at the rising edge |
| wide | input | 1 | 1 = 64-bit move, 0 = 32-bit move |
| wr_data | input | 64 | Write value |
| rd_data | output | 64 | Read value, 0 when not reading or trapped |
| trap | output | 1 | Illegal-access request: an access made outside kernel mode |
| priv_mode | output | 2 | Current privilege field of status |
| timer_irq | output | 1 | Sticky timer interrupt (hardware line 7) |
| irq_recalc | output | 1 | One-cycle pulse asking for an interrupt-flag recompute |
| rnd_idx | output | clog2(TLB_ENTRIES) | Current replacement index |

## Verification
The bench builds the block with TLB_ENTRIES = 48 and CLK_DIV = 2. With 48 entries, the six-bit wired field can hold values from 48 to 63. That brings the saturation of the replacement index within reach and makes the random window span 8 values for a wired count of 40. A divider of 2 lets the exact edge of each count increment and the timer match land within a few cycles. The bench can therefore check both the load-then-advance timing and the one-edge delay before the interrupt rises.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int NREG = 32;

    typedef logic [4:0]  sr_idx_t;
    typedef logic [63:0] word_t;

    // slot numbers decoded by the rest of the core
    localparam sr_idx_t SR_RANDOM  = 5'd1;
    localparam sr_idx_t SR_PGMASK  = 5'd5;
    localparam sr_idx_t SR_WIRED   = 5'd6;
    localparam sr_idx_t SR_COUNT   = 5'd9;
    localparam sr_idx_t SR_COMPARE = 5'd11;
    localparam sr_idx_t SR_STATUS  = 5'd12;
    localparam sr_idx_t SR_CAUSE   = 5'd13;
    localparam sr_idx_t SR_PRID    = 5'd15;
    localparam sr_idx_t SR_CONFIG  = 5'd16;

    localparam word_t PGMASK_BITS = 64'h0000_0000_01FF_E000;
    localparam int    MODE_LSB    = 3;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'b00,
        MODE_SUPER  = 2'b01,
        MODE_USER   = 2'b10,
        MODE_RSVD   = 2'b11
    } priv_e;

    typedef struct packed {
        logic    valid;
        sr_idx_t idx;
        word_t   data;
    } wr_req_t;

    function automatic word_t sext32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic is_readonly(input sr_idx_t i);
        return (i == SR_RANDOM) || (i == SR_PRID) || (i == SR_CONFIG);
    endfunction

    function automatic logic needs_recalc(input sr_idx_t i);
        return (i == SR_STATUS) || (i == SR_CAUSE) || (i == SR_COMPARE);
    endfunction

endpackage

// File: rtl/scr_timer.sv
module scr_timer #(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cnt_we,
    input  logic        cmp_we,
    input  logic [31:0] wdata,
    output logic [31:0] count,
    output logic [31:0] compare,
    output logic        irq
);
    localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_DIV - 1);

    logic [PW-1:0] pre_q;
    logic          tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            count   <= '0;
            compare <= '1;
            irq     <= 1'b0;
        end else begin
            if (cnt_we) begin
                count <= wdata;
                pre_q <= '0;
            end else if (tick) begin
                count <= count + 32'd1;
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + 1'b1;
            end

            if (cmp_we) begin
                compare <= wdata;
                irq     <= 1'b0;
            end else if (count == compare) begin
                irq <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/scr_rand.sv
module scr_rand #(
    parameter int TLB_ENTRIES = 64,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] wired,
    input  logic             wired_we,
    output logic [IDX_W-1:0] rnd
);
    localparam int W = IDX_W + 1;
    localparam logic [W-1:0] TLB_W = W'(TLB_ENTRIES);

    logic [W-1:0] wired_x;
    logic [W-1:0] span;
    logic [W-1:0] off_q;
    logic [W-1:0] sum;
    logic         saturated;

    assign wired_x   = {1'b0, wired};
    assign saturated = (wired_x >= TLB_W - 1'b1);
    assign span      = TLB_W - wired_x;
    assign sum       = saturated ? (TLB_W - 1'b1) : (wired_x + off_q);
    assign rnd       = sum[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || wired_we || saturated) begin
            off_q <= '0;
        end else if (off_q >= span - 1'b1) begin
            off_q <= '0;
        end else begin
            off_q <= off_q + 1'b1;
        end
    end
endmodule

// File: rtl/scr_rdmux.sv
module scr_rdmux
    import scr_pkg::*;
#(
    parameter int    IDX_W    = 6,
    parameter word_t PRID_VAL = 64'h0,
    parameter word_t CFG_VAL  = 64'h0
) (
    input  logic             rd_en,
    input  logic             trap,
    input  logic             wide,
    input  sr_idx_t          idx,
    input  word_t            stored,
    input  logic [IDX_W-1:0] rnd,
    input  logic [31:0]      count,
    input  logic [31:0]      compare,
    output word_t            rd_data
);
    word_t raw;

    always_comb begin
        case (idx)
            SR_RANDOM:  raw = word_t'(rnd);
            SR_COUNT:   raw = sext32(count);
            SR_COMPARE: raw = sext32(compare);
            SR_PRID:    raw = PRID_VAL;
            SR_CONFIG:  raw = CFG_VAL;
            default:    raw = stored;
        endcase
    end

    always_comb begin
        if (!rd_en || trap)
            rd_data = '0;
        else if (wide)
            rd_data = raw;
        else
            rd_data = sext32(raw[31:0]);
    end
endmodule

// File: rtl/scr_file.sv
module scr_file
    import scr_pkg::*;
#(
    parameter int    TLB_ENTRIES = 64,
    parameter int    CLK_DIV     = 4,
    parameter word_t PRID_VAL    = 64'h0000_0000_0000_0A51,
    parameter word_t CFG_VAL     = 64'h0000_0000_8000_6460,
    localparam int   IDX_W       = $clog2(TLB_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       acc_idx,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic             wide,
    input  logic [63:0]      wr_data,
    output logic [63:0]      rd_data,
    output logic             trap,
    output logic [1:0]       priv_mode,
    output logic             timer_irq,
    output logic             irq_recalc,
    output logic [IDX_W-1:0] rnd_idx
);
    word_t            regs [NREG];
    priv_e            mode;
    wr_req_t          req;
    word_t            fdata;
    logic [31:0]      count_v;
    logic [31:0]      compare_v;
    logic [IDX_W-1:0] wired_cur;

    assign mode      = priv_e'(regs[SR_STATUS][MODE_LSB +: 2]);
    assign priv_mode = mode;
    assign trap      = (rd_en || wr_en) && (mode != MODE_KERNEL);
    assign wired_cur = regs[SR_WIRED][IDX_W-1:0];

    always_comb begin
        req.valid = wr_en && !trap;
        req.idx   = acc_idx;
        req.data  = wide ? wr_data : {32'b0, wr_data[31:0]};
    end

    // per-slot write filter
    always_comb begin
        case (req.idx)
            SR_PGMASK: fdata = req.data & PGMASK_BITS;
            SR_WIRED:  fdata = word_t'(req.data[IDX_W-1:0]);
            default:   fdata = req.data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            irq_recalc <= 1'b0;
        end else begin
            if (req.valid && !is_readonly(req.idx) &&
                req.idx != SR_COUNT && req.idx != SR_COMPARE)
                regs[req.idx] <= fdata;
            irq_recalc <= req.valid && needs_recalc(req.idx);
        end
    end

    scr_timer #(.CLK_DIV(CLK_DIV)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cnt_we  (req.valid && req.idx == SR_COUNT),
        .cmp_we  (req.valid && req.idx == SR_COMPARE),
        .wdata   (req.data[31:0]),
        .count   (count_v),
        .compare (compare_v),
        .irq     (timer_irq)
    );

    scr_rand #(.TLB_ENTRIES(TLB_ENTRIES), .IDX_W(IDX_W)) u_rand (
        .clk      (clk),
        .rst      (rst),
        .wired    (wired_cur),
        .wired_we (req.valid && req.idx == SR_WIRED),
        .rnd      (rnd_idx)
    );

    scr_rdmux #(.IDX_W(IDX_W), .PRID_VAL(PRID_VAL), .CFG_VAL(CFG_VAL)) u_rdmux (
        .rd_en   (rd_en),
        .trap    (trap),
        .wide    (wide),
        .idx     (acc_idx),
        .stored  (regs[acc_idx]),
        .rnd     (rnd_idx),
        .count   (count_v),
        .compare (compare_v),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/scr_chk.sv
module scr_chk
    import scr_pkg::*;
#(
    parameter int    TLB_ENTRIES = 64,
    parameter int    IDX_W       = 6,
    parameter word_t PRID_VAL    = 64'h0
) (
    input logic             clk,
    input logic             rst,
    input logic [4:0]       acc_idx,
    input logic             rd_en,
    input logic             wr_en,
    input logic             wide,
    input logic [63:0]      rd_data,
    input logic             trap,
    input logic [1:0]       priv_mode,
    input logic             timer_irq,
    input logic             irq_recalc,
    input logic [IDX_W-1:0] rnd_idx,
    input logic [IDX_W-1:0] wired
);
    localparam int W = IDX_W + 1;
    logic [W-1:0] lim;
    assign lim = W'(TLB_ENTRIES - 1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!timer_irq && priv_mode == 2'b00));

    // R2
    rnd_window_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, rnd_idx} <= lim) &&
        (({1'b0, wired} >= lim) ? ({1'b0, rnd_idx} == lim) : (rnd_idx >= wired)));

    // R3
    prid_const_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !trap && wide && acc_idx == SR_PRID) |-> rd_data == PRID_VAL);

    // R4
    cmp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trap && acc_idx == SR_COMPARE) |=> !timer_irq);

    // R4
    recalc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !trap && needs_recalc(acc_idx)) |=> irq_recalc);

    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (timer_irq && !(wr_en && !trap && acc_idx == SR_COMPARE)) |=> timer_irq);

    // R9
    trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        trap |-> (rd_data == '0));

    // R9
    trap_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && trap) |=> !irq_recalc);
endmodule

bind scr_file scr_chk #(
    .TLB_ENTRIES (TLB_ENTRIES),
    .IDX_W       (IDX_W),
    .PRID_VAL    (PRID_VAL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_idx    (acc_idx),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wide       (wide),
    .rd_data    (rd_data),
    .trap       (trap),
    .priv_mode  (priv_mode),
    .timer_irq  (timer_irq),
    .irq_recalc (irq_recalc),
    .rnd_idx    (rnd_idx),
    .wired      (wired_cur)
);

// File: tb/sim_scr_file.sv
`timescale 1ns/1ps
module sim_scr_file;
    import scr_pkg::*;

    localparam int    TLB = 48;
    localparam int    DIV = 2;
    localparam int    IW  = $clog2(TLB);
    localparam word_t PRID = 64'h0000_0000_0000_0A51;
    localparam word_t CFG  = 64'h0000_0000_8000_6460;

    localparam int K_RD = 0, K_TRAP = 1, K_IRQ = 2, K_RCL = 3, K_PRIV = 4, K_RANGE = 5, K_RND = 6;

    typedef struct {
        int          kind;
        logic [63:0] a;
        logic [63:0] b;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    acc_idx = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic          wide = 1'b0;
    logic [63:0]   wr_data = '0;
    logic [63:0]   rd_data;
    logic          trap;
    logic [1:0]    priv_mode;
    logic          timer_irq;
    logic          irq_recalc;
    logic [IW-1:0] rnd_idx;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    scr_file #(.TLB_ENTRIES(TLB), .CLK_DIV(DIV), .PRID_VAL(PRID), .CFG_VAL(CFG)) u0 (
        .clk(clk), .rst(rst), .acc_idx(acc_idx), .rd_en(rd_en), .wr_en(wr_en),
        .wide(wide), .wr_data(wr_data), .rd_data(rd_data), .trap(trap),
        .priv_mode(priv_mode), .timer_irq(timer_irq), .irq_recalc(irq_recalc),
        .rnd_idx(rnd_idx)
    );

    task automatic push(input int kind, input logic [63:0] a, input logic [63:0] b, input string tag);
        item_t it;
        it.kind = kind; it.a = a; it.b = b; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [63:0] got;
                logic ok;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    begin got = rd_data;               ok = (got == it.a); end
                    K_TRAP:  begin got = 64'(trap);             ok = (got == it.a); end
                    K_IRQ:   begin got = 64'(timer_irq);        ok = (got == it.a); end
                    K_RCL:   begin got = 64'(irq_recalc);       ok = (got == it.a); end
                    K_PRIV:  begin got = 64'(priv_mode);        ok = (got == it.a); end
                    K_RANGE: begin got = rd_data;               ok = (got >= it.a) && (got <= it.b); end
                    default: begin got = 64'(rnd_idx);          ok = (got == it.a); end
                endcase
                n_chk++;
                if (!ok) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h (upper %h)", it.tag, got, it.a, it.b);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] i, input logic w, input logic [63:0] d);
        @(negedge clk);
        acc_idx = i; wide = w; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // read in the current cycle, check, release at the next negedge
    task automatic look(input logic [4:0] i, input logic w, input logic [63:0] e, input string tag);
        acc_idx = i; wide = w; rd_en = 1'b1;
        push(K_RD, e, 64'h0, tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        push(K_IRQ, 0, 0, "R1 timer_irq after reset");
        push(K_PRIV, 0, 0, "R1 kernel mode after reset");
        @(negedge clk);
        look(SR_COUNT, 1, 64'h0, "R1 count after reset");
        look(SR_COMPARE, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R1 compare after reset");
        look(SR_STATUS, 1, 64'h0, "R1 status after reset");
        look(SR_WIRED, 1, 64'h0, "R1 wired after reset");

        // R5 count load and divider
        wr(SR_COUNT, 0, 64'd100);
        look(SR_COUNT, 1, 64'd100, "R5 count loaded");
        look(SR_COUNT, 1, 64'd100, "R5 count held one cycle");
        look(SR_COUNT, 1, 64'd101, "R5 count advanced");

        // R10 / R7 plain storage and move widths
        wr(5'd20, 1, 64'h1234_5678_9ABC_DEF0);
        look(5'd20, 1, 64'h1234_5678_9ABC_DEF0, "R10 full width store");
        look(5'd20, 0, 64'hFFFF_FFFF_9ABC_DEF0, "R7 narrow read sign extends");
        wr(5'd20, 0, 64'hAAAA_BBBB_1234_5678);
        look(5'd20, 1, 64'h0000_0000_1234_5678, "R7 narrow write zeroes upper");

        // R8 masks
        wr(SR_PGMASK, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        look(SR_PGMASK, 1, 64'h0000_0000_01FF_E000, "R8 page mask filtered");

        // R3 read-only slots
        wr(SR_PRID, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(SR_CONFIG, 1, 64'h0);
        look(SR_PRID, 1, PRID, "R3 prid unchanged");
        look(SR_CONFIG, 1, CFG, "R3 config unchanged");
        look(SR_CONFIG, 0, 64'hFFFF_FFFF_8000_6460, "R7 config narrow read");

        // R2 replacement index
        wr(SR_WIRED, 1, 64'd40);
        wr(SR_RANDOM, 1, 64'd3);
        for (int k = 0; k < 12; k++)
            begin
                acc_idx = SR_RANDOM; wide = 1'b1; rd_en = 1'b1;
                push(K_RANGE, 64'd40, 64'd47, "R2 random within window");
                @(negedge clk);
                rd_en = 1'b0;
            end
        wr(SR_WIRED, 1, 64'd47);
        push(K_RND, 64'd47, 0, "R2 rnd_idx at top");
        look(SR_RANDOM, 1, 64'd47, "R2 random with wired at top");
        wr(SR_WIRED, 1, 64'hFF);
        look(SR_WIRED, 1, 64'd63, "R8 wired masked to index width");
        look(SR_RANDOM, 1, 64'd47, "R2 random saturates");

        // R6 timer match
        wr(SR_COMPARE, 0, 64'h200);
        wr(SR_COUNT, 0, 64'h1FD);
        push(K_IRQ, 0, 0, "R6 no irq at load");
        idle(6);
        push(K_IRQ, 0, 0, "R6 no irq on matching edge");
        idle(1);
        push(K_IRQ, 1, 0, "R6 irq one edge after match");
        idle(10);
        push(K_IRQ, 1, 0, "R6 irq sticky");

        // R9 user mode
        wr(SR_STATUS, 0, 64'h10);
        push(K_PRIV, 2, 0, "R9 mode from status");
        push(K_RCL, 1, 0, "R4 recalc after status write");
        @(negedge clk);
        acc_idx = SR_COMPARE; wide = 1'b0; wr_data = 64'h0; wr_en = 1'b1;
        push(K_TRAP, 1, 0, "R9 trap on user write");
        @(negedge clk);
        wr_en = 1'b0;
        push(K_IRQ, 1, 0, "R9 trapped compare write dropped");
        push(K_RCL, 0, 0, "R9 no recalc for trapped write");
        push(K_TRAP, 1, 0, "R9 trap on user read");
        look(SR_STATUS, 1, 64'h0, "R9 trapped read returns zero");

        // R4 compare clears irq
        do_reset();
        wr(SR_COMPARE, 0, 64'h40);
        wr(SR_COUNT, 0, 64'h40);
        idle(2);
        push(K_IRQ, 1, 0, "R6 irq at immediate match");
        wr(SR_COMPARE, 0, 64'h9000);
        push(K_IRQ, 0, 0, "R4 compare write clears irq");
        push(K_RCL, 1, 0, "R4 recalc after compare write");
        idle(1);
        push(K_RCL, 0, 0, "R4 recalc lasts one cycle");
        wr(SR_CAUSE, 1, 64'h300);
        push(K_RCL, 1, 0, "R4 recalc after cause write");
        wr(5'd20, 1, 64'd5);
        push(K_RCL, 0, 0, "R4 no recalc for plain write");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule